// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is the tick timer found in a processor's system-control unit. A 32-bit counter advances by one on every cycle in which the tick enable is high. A 32-bit match register sits beside it. When the counter steps onto the match value while counting is enabled, the timer latches an interrupt. The interrupt stays latched until software writes the match register again or the block is reset.

Software reaches both registers through a small port. The port has one write strobe, one read address and a combinational read path. A freeze input stops the counter. While it is high, a counter write stores the given value as-is.

A 3-bit selector picks which one of eight interrupt outputs carries the timer request. The selector can change at any time. A build parameter adds a pending flag that mirrors the latched request. Masking, the wider cause/status logic and the pipeline lie outside this block.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset the counter reads 1, the match register reads 0, all eight interrupt lines are low and the pending flag is low.
- R2: On each clock edge where tick_en is high, freeze is low and no counter write occurs, the counter increases by one modulo 2^32, so 0xFFFFFFFF is followed by 0.
- R3: A write with wr_addr = 0 loads the counter from wr_data at the next edge and takes priority over an increment in the same cycle.
- R4: While freeze is high, the counter holds its value, and a counter write still stores wr_data exactly.
- R5: When an increment makes the counter equal to the match register, the interrupt is asserted one clock edge later. This also holds when the counter wraps to 0 with a match value of 0.
- R6: No interrupt is raised when freeze is high in the cycle after the counter reaches the match value. No interrupt is raised when the counter reaches the value by a write rather than an increment.
- R7: A write with wr_addr = 1 loads the match register, deasserts the interrupt and clears the pending flag at the next edge. This clear wins over a match detected in the same cycle.
- R8: Once asserted, the interrupt stays high until a match-register write or reset, whatever the counter does meanwhile.
- R9: irq_out is an 8-bit vector in which only bit line_sel may be high, and it follows line_sel combinationally while the request is latched.
- R10: With HAS_PEND = 1, pend_flag is high exactly while the interrupt request is latched.
- R11: rd_data shows the counter when rd_addr = 0 and the match register when rd_addr = 1, and reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| freeze | input | 1 | Stops counting and suppresses matches |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 counter, 1 match register |
| wr_data | input | 32 | Write value |
| rd_addr | input | 1 | Read select: 0 counter, 1 match register |
| rd_data | output | 32 | Selected register value |
| line_sel | input | 3 | Interrupt line selector |
| irq_out | output | 8 | Interrupt lines, at most one high |
| pend_flag | output | 1 | Timer pending flag |

## Verification
The bench builds the block with its defaults: a 32-bit counter, a 3-bit line selector and HAS_PEND = 1. Full width lets the bench load the counter near 0xFFFFFFFF and check both the wrap and a match at zero. The pending flag being present lets its set and clear be checked against the interrupt. Match timing is checked edge by edge, including freeze at the match edge and a match-register write racing a match.

// File: rtl/tct_pkg.sv
package tct_pkg;

  localparam logic ADDR_COUNT   = 1'b0;
  localparam logic ADDR_COMPARE = 1'b1;

  typedef struct packed {
    logic loadCount;
    logic loadCompare;
    logic stepCount;
  } tctStrobes_t;

endpackage

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RST_COUNT = 1,
  parameter int RST_CMP   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tctStrobes_t      strobes,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             hitNow,
  output logic             steppedLast
);

  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] COUNT_INI = CNT_W'(RST_COUNT);
  localparam logic [CNT_W-1:0] CMP_INI   = CNT_W'(RST_CMP);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] compareReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countReg    <= COUNT_INI;
      steppedLast <= 1'b0;
    end else begin
      if (strobes.loadCount)      countReg <= wrData;
      else if (strobes.stepCount) countReg <= countReg + ONE;
      steppedLast <= strobes.stepCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   compareReg <= CMP_INI;
    else if (strobes.loadCompare) compareReg <= wrData;
  end

  assign hitNow = (countReg == compareReg);
  assign rdData = (rdAddr == ADDR_COMPARE) ? compareReg : countReg;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.stepCount |=> countReg == $past(countReg) + ONE); // R2
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadCount |=> countReg == $past(wrData)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.loadCount && !strobes.stepCount) |=> $stable(countReg)); // R4
  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadCompare |=> compareReg == $past(wrData)); // R7

endmodule

// File: rtl/tct_ctrl.sv
module tct_ctrl
  import tct_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter bit HAS_PEND = 1'b1,
  localparam int LINES   = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             freeze,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [SEL_W-1:0] lineSel,
  input  logic             hitNow,
  input  logic             steppedLast,
  output tctStrobes_t      strobes,
  output logic [LINES-1:0] irqVec,
  output logic             pendFlag
);

  logic irqLatch;
  logic matchEvt;

  always_comb begin
    strobes.loadCount   = wrEn && (wrAddr == ADDR_COUNT);
    strobes.loadCompare = wrEn && (wrAddr == ADDR_COMPARE);
    strobes.stepCount   = tickEn && !freeze && !strobes.loadCount;
  end

  // a match counts only when the counter arrived by incrementing
  assign matchEvt = steppedLast && hitNow && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n)                   irqLatch <= 1'b0;
    else if (strobes.loadCompare) irqLatch <= 1'b0;
    else if (matchEvt)            irqLatch <= 1'b1;
  end

  always_comb begin
    irqVec = '0;
    irqVec[lineSel] = irqLatch;
  end

  generate
    if (HAS_PEND) begin : g_pend
      logic pendReg;
      always_ff @(posedge clk) begin
        if (!rst_n)                   pendReg <= 1'b0;
        else if (strobes.loadCompare) pendReg <= 1'b0;
        else if (matchEvt)            pendReg <= 1'b1;
      end
      assign pendFlag = pendReg;
      AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        pendFlag == (irqVec != '0)); // R10
    end else begin : g_nopend
      assign pendFlag = 1'b0;
    end
  endgenerate

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irqVec)); // R9
  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadCompare |=> irqVec == '0); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irqLatch && !strobes.loadCompare) |=> irqLatch); // R8
  AST_FREEZE_NOIRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqLatch && freeze) |=> !irqLatch); // R6
  AST_MATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (matchEvt && !strobes.loadCompare) |=> irqLatch); // R5

endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tct_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 3,
  parameter bit HAS_PEND  = 1'b1,
  parameter int RST_COUNT = 1,
  parameter int RST_CMP   = 0,
  localparam int LINES    = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [SEL_W-1:0] line_sel,
  output logic [LINES-1:0] irq_out,
  output logic             pend_flag
);

  tctStrobes_t strobes;
  logic        hitNow;
  logic        steppedLast;

  tct_ctrl #(
    .SEL_W    (SEL_W),
    .HAS_PEND (HAS_PEND)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tickEn      (tick_en),
    .freeze      (freeze),
    .wrEn        (wr_en),
    .wrAddr      (wr_addr),
    .lineSel     (line_sel),
    .hitNow      (hitNow),
    .steppedLast (steppedLast),
    .strobes     (strobes),
    .irqVec      (irq_out),
    .pendFlag    (pend_flag)
  );

  tct_datapath #(
    .CNT_W     (CNT_W),
    .RST_COUNT (RST_COUNT),
    .RST_CMP   (RST_CMP)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .wrData      (wr_data),
    .rdAddr      (rd_addr),
    .rdData      (rd_data),
    .hitNow      (hitNow),
    .steppedLast (steppedLast)
  );

endmodule

// File: tb/test_tick_compare_timer.sv
module test_tick_compare_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, freeze, wr_en, wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [2:0]  line_sel;
  logic [7:0]  irq_out;
  logic        pend_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_compare_timer i_tick_compare_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .line_sel(line_sel),
    .irq_out(irq_out), .pend_flag(pend_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance n edges, returning at the following falling edge
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic doReset();
    rst_n = 1'b0; tick_en = 1'b0; freeze = 1'b0; wr_en = 1'b0;
    wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0; line_sel = 3'd0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    readReg(1'b0, v); chk("R1 count", v, 32'd1);
    readReg(1'b1, v); chk("R1 compare", v, 32'd0);
    chk("R1 irq", {24'd0, irq_out}, 32'd0);
    chk("R1 pend", {31'd0, pend_flag}, 32'd0);
  endtask

  task automatic testCountWrap();
    logic [31:0] v;
    wr(1'b1, 32'd100);
    wr(1'b0, 32'hFFFF_FFFE);
    tick_en = 1'b1; cyc(1);
    readReg(1'b0, v); chk("R2 step", v, 32'hFFFF_FFFF);
    cyc(1);
    readReg(1'b0, v); chk("R2 wrap", v, 32'd0);
    tick_en = 1'b0; cyc(1);
    readReg(1'b0, v); chk("R2 no tick hold", v, 32'd0);
  endtask

  task automatic testWritePriority();
    logic [31:0] v;
    tick_en = 1'b1;
    wr(1'b0, 32'h0000_0040);
    tick_en = 1'b0;
    readReg(1'b0, v); chk("R3 write beats step", v, 32'h40);
  endtask

  task automatic testFreeze();
    logic [31:0] v;
    freeze = 1'b1; tick_en = 1'b1;
    cyc(3);
    readReg(1'b0, v); chk("R4 frozen hold", v, 32'h40);
    wr(1'b0, 32'h1234_5678);
    cyc(1);
    readReg(1'b0, v); chk("R4 frozen write", v, 32'h1234_5678);
    freeze = 1'b0; tick_en = 1'b0;
  endtask

  task automatic testMatch();
    logic [31:0] v;
    wr(1'b1, 32'd10);
    wr(1'b0, 32'd7);
    line_sel = 3'd2;
    tick_en = 1'b1; cyc(3);
    readReg(1'b0, v); chk("R5 at compare", v, 32'd10);
    chk("R5 not yet", {24'd0, irq_out}, 32'd0);
    tick_en = 1'b0; cyc(1);
    chk("R5 irq raised", {24'd0, irq_out}, 32'h04);
    chk("R10 pend set", {31'd0, pend_flag}, 32'd1);
    tick_en = 1'b1; cyc(5); tick_en = 1'b0;
    chk("R8 sticky", {24'd0, irq_out}, 32'h04);
    line_sel = 3'd5; #1;
    chk("R9 reselect", {24'd0, irq_out}, 32'h20);
    readReg(1'b1, v); chk("R11 compare read", v, 32'd10);
    readReg(1'b0, v); chk("R11 count read", v, 32'd15);
    readReg(1'b0, v); chk("R11 no side effect", v, 32'd15);
    wr(1'b1, 32'd500);
    chk("R7 irq cleared", {24'd0, irq_out}, 32'd0);
    chk("R7 pend cleared", {31'd0, pend_flag}, 32'd0);
  endtask

  task automatic testFreezeAtMatch();
    wr(1'b1, 32'd20);
    wr(1'b0, 32'd19);
    tick_en = 1'b1; cyc(1);
    tick_en = 1'b0; freeze = 1'b1; cyc(1);
    freeze = 1'b0; cyc(2);
    chk("R6 freeze suppresses", {24'd0, irq_out}, 32'd0);
    wr(1'b0, 32'd20);
    cyc(2);
    chk("R6 write no match", {24'd0, irq_out}, 32'd0);
  endtask

  task automatic testClearWins();
    wr(1'b0, 32'd29);
    wr(1'b1, 32'd30);
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    wr(1'b1, 32'd30);
    chk("R7 clear beats match", {24'd0, irq_out}, 32'd0);
    cyc(2);
    chk("R7 stays clear", {24'd0, irq_out}, 32'd0);
  endtask

  task automatic testWrapMatch();
    wr(1'b1, 32'd0);
    wr(1'b0, 32'hFFFF_FFFF);
    line_sel = 3'd7;
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    cyc(1);
    chk("R5 wrap match", {24'd0, irq_out}, 32'h80);
  endtask

  initial begin
    testReset();
    testCountWrap();
    testWritePriority();
    testFreeze();
    testMatch();
    testFreezeAtMatch();
    testClearWins();
    testWrapMatch();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule